// File: doc/BRIEF.md
# Newton-Raphson Fixed-Point Divider

This block divides a signed dividend by a positive divisor without a divide array. It scales the divisor by a power of two so that its leading one sits at bit 15, which puts the value in [0.5, 1) with 16 fractional bits. A 32-entry seed table, indexed by the five bits below that leading one, supplies a first guess of the reciprocal. One or two Newton-Raphson passes refine that guess. The refined reciprocal is then multiplied by the dividend. The shift applied to that last product undoes the normalisation and scales the quotient so that the value one is coded as 2^RADIX.

All arithmetic runs on one external signed multiplier. This lets a design that already owns a multiplier share it with the divider. The multiplier takes a start strobe, two 18-bit operands and a shift amount. It returns `(a*b) >>> shift` with a one-cycle ready pulse, three cycles after the start. A client raises `req` for one cycle with the operands and the pass count. It then waits for the one-cycle `ready` pulse, when `quotient` is valid.

Top module: `nr_divider`

## Requirements
- R1: When `req` is high and the block is idle, the operands are captured, and `busy` is high from the next cycle until the cycle in which `ready` pulses.
- R2: With `req_two_pass` = 0 (one pass) and a dividend N ≥ 0, the quotient q for divisor d in 1..32767 satisfies Q − Q/1024 − 2 ≤ q ≤ Q, where Q = N·2^RADIX/d is computed in real arithmetic.
- R3: With `req_two_pass` = 1 (two passes), the quotient satisfies Q − Q/8192 − 2 ≤ q ≤ Q.
- R4: When the dividend equals the divisor, a single pass returns a value in [2^RADIX − 2^(RADIX−10) − 2, 2^RADIX], and two passes return a value in [2^RADIX − 2, 2^RADIX].
- R5: With the three-cycle multiplier, `ready` is high in the 13th cycle after the request cycle for one pass, and in the 21st cycle for two passes.
- R6: `ready` stays high for exactly one cycle, and `busy` is low in that cycle and in the cycle after it.
- R7: A request made while `busy` is high is ignored. The running division keeps its operands and its timing, and no extra result is produced.
- R8: Every multiply is issued by a one-cycle `mul_start` pulse, and only while `busy` is high. A division issues 3 multiplies with one pass and 5 with two passes.
- R9: `quotient` changes only in a cycle in which `ready` is high. It holds its value while idle, whatever the operand inputs do.
- R10: During reset, `busy`, `ready` and `mul_start` are low and `quotient` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-cycle request strobe |
| req_dividend | input | W | Signed dividend |
| req_divisor | input | W | Divisor, 1 to 2^(W−3)−1 |
| req_two_pass | input | 1 | 0 selects one refinement pass, 1 selects two |
| busy | output | 1 | Division in progress |
| ready | output | 1 | One-cycle pulse when the quotient is valid |
| quotient | output | 2W | Quotient scaled by 2^RADIX |
| mul_start | output | 1 | Multiplier start strobe |
| mul_a | output | W | Multiplier operand a |
| mul_b | output | W | Multiplier operand b |
| mul_shift | output | clog2(2W) | Arithmetic right shift applied to the product |
| mul_ready | input | 1 | Multiplier result pulse |
| mul_result | input | 2W | Shifted multiplier product |

## Verification
Three dividend/divisor patterns are swept across the full divisor range, with a step that grows with the divisor, at both pass counts.
- The x/x pattern hits the exact value 2^RADIX. It exposes seed-table or normalisation faults as a deviation from unity in each divisor octave.
- The x/(x+2500) pattern keeps the quotient below one.
- The (x+2500)/x pattern drives it up to several thousand times unity. Together with the first pattern, this checks that the final shift tracks the leading-one position in both directions.

Separate runs inject a request mid-division and leave the block idle with changing inputs. These show that the captured operands and the held quotient are not disturbed.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_XA    = 2'd1,
      ST_XT    = 2'd2,
      ST_FINAL = 2'd3
   } nr_state_e;

   // Rounded reciprocal at the midpoint of seed slice i, for an index of ib bits.
   // The returned value carries ib+1 bits and is later shifted into radix 16.
   function automatic int seed_entry(input int ib, input int i);
      int num;
      int den;
      num = 1 << (2 * ib + 2);
      den = (1 << (ib + 1)) + 2 * i + 1;
      return (2 * num / den + 1) / 2;
   endfunction

endpackage

// File: rtl/nr_div_norm.sv
module nr_div_norm #(
   parameter int W   = 18,
   parameter int MSB = 15,
   parameter int KW  = 4
) (
   input  logic [W-1:0]  value,
   output logic [W-1:0]  norm,
   output logic [KW-1:0] lead
);

   // Highest set bit at or below MSB; the value is moved up so it lands on MSB.
   always_comb begin
      lead = '0;
      for (int b = 0; b <= MSB; b++) begin
         if (value[b]) lead = KW'(b);
      end
      norm = value << (MSB - int'(lead));
   end

endmodule

// File: rtl/nr_div_seed.sv
module nr_div_seed #(
   parameter int W        = 18,
   parameter int F        = 16,
   parameter int IDX_BITS = 5
) (
   input  logic [IDX_BITS-1:0] idx,
   output logic [W-1:0]        seed
);

   localparam int EW    = IDX_BITS + 1;
   localparam int DEPTH = 1 << IDX_BITS;
   localparam int SH    = F - IDX_BITS;

   logic [EW-1:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = EW'(nr_div_pkg::seed_entry(IDX_BITS, i));
   end

   assign seed = {{(W-EW){1'b0}}, rom[idx]} << SH;

endmodule

// File: rtl/nr_divider.sv
module nr_divider #(
   parameter int  W        = 18,
   parameter int  RADIX    = 15,
   parameter int  IDX_BITS = 5,
   localparam int QW       = 2 * W,
   localparam int SHW      = $clog2(2 * W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req,
   input  logic signed [W-1:0]   req_dividend,
   input  logic [W-1:0]          req_divisor,
   input  logic                  req_two_pass,
   output logic                  busy,
   output logic                  ready,
   output logic [QW-1:0]         quotient,
   output logic                  mul_start,
   output logic signed [W-1:0]   mul_a,
   output logic signed [W-1:0]   mul_b,
   output logic [SHW-1:0]        mul_shift,
   input  logic                  mul_ready,
   input  logic signed [QW-1:0]  mul_result
);

   import nr_div_pkg::*;

   localparam int F        = W - 2;          // reciprocal fraction bits
   localparam int NORM_MSB = F - 1;          // leading-one position after scaling
   localparam int KW       = $clog2(NORM_MSB + 1);
   localparam int SH_BASE  = F + 1 - RADIX;  // final shift = SH_BASE + lead

   if (W < 8) begin : g_bad_width
      $error("nr_divider: W must be at least 8");
   end
   if (RADIX < 0 || RADIX > F + 1) begin : g_bad_radix
      $error("nr_divider: RADIX out of range");
   end
   if (IDX_BITS < 1 || IDX_BITS > NORM_MSB - 1) begin : g_bad_idx
      $error("nr_divider: IDX_BITS out of range");
   end

   nr_state_e      state_q;
   logic [W-1:0]   x_q, a_q, t_q;
   logic [W-1:0]   n_q;
   logic [KW-1:0]  k_q;
   logic           extra_q;
   logic           start_q, ready_q;
   logic [QW-1:0]  quot_q;

   logic [W-1:0]   norm_c, seed_c;
   logic [KW-1:0]  lead_c;

   nr_div_norm #(.W(W), .MSB(NORM_MSB), .KW(KW)) u_norm (
      .value (req_divisor),
      .norm  (norm_c),
      .lead  (lead_c)
   );

   nr_div_seed #(.W(W), .F(F), .IDX_BITS(IDX_BITS)) u_seed (
      .idx  (norm_c[NORM_MSB-1 -: IDX_BITS]),
      .seed (seed_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         x_q     <= '0;
         a_q     <= '0;
         t_q     <= '0;
         n_q     <= '0;
         k_q     <= '0;
         extra_q <= 1'b0;
         start_q <= 1'b0;
         ready_q <= 1'b0;
         quot_q  <= '0;
      end else begin
         start_q <= 1'b0;
         ready_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req) begin
                  a_q     <= norm_c;
                  x_q     <= seed_c;
                  n_q     <= req_dividend;
                  k_q     <= lead_c;
                  extra_q <= req_two_pass;
                  start_q <= 1'b1;
                  state_q <= ST_XA;
               end
            end
            ST_XA: begin
               if (mul_ready) begin
                  // ones' complement of x*a stands in for 2 - x*a
                  t_q     <= {{(W-F-1){1'b0}}, ~mul_result[F:0]};
                  start_q <= 1'b1;
                  state_q <= ST_XT;
               end
            end
            ST_XT: begin
               if (mul_ready) begin
                  x_q     <= mul_result[W-1:0];
                  start_q <= 1'b1;
                  if (extra_q) begin
                     extra_q <= 1'b0;
                     state_q <= ST_XA;
                  end else begin
                     state_q <= ST_FINAL;
                  end
               end
            end
            ST_FINAL: begin
               if (mul_ready) begin
                  quot_q  <= mul_result;
                  ready_q <= 1'b1;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mul_a     = x_q;
      mul_b     = a_q;
      mul_shift = SHW'(F);
      case (state_q)
         ST_XT:    mul_b = t_q;
         ST_FINAL: begin
            mul_b     = n_q;
            mul_shift = SHW'(SH_BASE) + SHW'(k_q);
         end
         default: ;
      endcase
   end

   assign busy      = (state_q != ST_IDLE);
   assign ready     = ready_q;
   assign quotient  = quot_q;
   assign mul_start = start_q;

endmodule

// File: rtl/nr_divider_chk.sv
module nr_divider_chk #(
   parameter int QW = 36
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req,
   input logic          busy,
   input logic          ready,
   input logic          mul_start,
   input logic          mul_ready,
   input logic [QW-1:0] quotient
);

   a_r1_req_starts: assert property (@(posedge clk) disable iff (!rst_n)
      (req && !busy) |=> busy);

   a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   a_r6_ready_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!busy && $past(busy)));

   a_r7_busy_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req && !mul_ready) |=> busy);

   a_r8_start_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |-> busy);

   a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |=> !mul_start);

   a_r8_no_start_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
      mul_ready |-> !mul_start);

   a_r9_quot_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(quotient) |-> ready);

endmodule

bind nr_divider nr_divider_chk #(.QW(QW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req       (req),
   .busy      (busy),
   .ready     (ready),
   .mul_start (mul_start),
   .mul_ready (mul_ready),
   .quotient  (quotient)
);

// File: tb/test_nr_divider.sv
module test_nr_divider;

   localparam int W   = 18;
   localparam int R   = 15;
   localparam int QW  = 2 * W;
   localparam int SHW = $clog2(2 * W);
   localparam real UNITY = 32768.0;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 req = 1'b0;
   logic signed [W-1:0]  req_dividend = '0;
   logic [W-1:0]         req_divisor = '0;
   logic                 req_two_pass = 1'b0;
   logic                 busy, ready;
   logic [QW-1:0]        quotient;
   logic                 mul_start;
   logic signed [W-1:0]  mul_a, mul_b;
   logic [SHW-1:0]       mul_shift;
   logic                 mul_ready;
   logic signed [QW-1:0] mul_result;

   int total = 0;
   int failed = 0;
   int n_starts = 0;
   int n_ready = 0;

   always #10 clk = ~clk;

   nr_divider #(.W(W), .RADIX(R)) i_nr_divider (
      .clk          (clk),
      .rst_n        (rst_n),
      .req          (req),
      .req_dividend (req_dividend),
      .req_divisor  (req_divisor),
      .req_two_pass (req_two_pass),
      .busy         (busy),
      .ready        (ready),
      .quotient     (quotient),
      .mul_start    (mul_start),
      .mul_a        (mul_a),
      .mul_b        (mul_b),
      .mul_shift    (mul_shift),
      .mul_ready    (mul_ready),
      .mul_result   (mul_result)
   );

   // Behavioural three-stage multiplier
   logic [2:0]           mvld;
   logic signed [QW-1:0] mp0, mp1, mp2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mvld <= '0;
      end else begin
         mvld <= {mvld[1:0], mul_start};
         mp0  <= (mul_a * mul_b) >>> mul_shift;
         mp1  <= mp0;
         mp2  <= mp1;
      end
   end
   assign mul_ready  = mvld[2];
   assign mul_result = mp2;

   always @(posedge clk) begin
      if (rst_n && mul_start) n_starts <= n_starts + 1;
      if (rst_n && ready)     n_ready  <= n_ready + 1;
   end

   task automatic summary();
      $display("%0d/%0d checks passed", total - failed, total);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input real act, input real exp);
      total++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %0.3f expected %0.3f", tag, what, act, exp);
      end
   endtask

   task automatic run_div(input int n, input int d, input bit two, input bit inject,
                          output longint q, output int lat, output int starts);
      int s0;
      @(negedge clk);
      req = 1'b1;
      req_dividend = W'(n);
      req_divisor  = W'(d);
      req_two_pass = two;
      s0 = n_starts;
      @(negedge clk);
      req = 1'b0;
      lat = 1;
      check(busy == 1'b1, "R1", "busy after request", real'(busy), 1.0);
      while (!ready && lat < 100) begin
         if (inject && lat == 3) begin
            req = 1'b1;
            req_dividend = 18'sd5;
            req_divisor  = 18'd3;
            req_two_pass = 1'b1;
         end else begin
            req = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      req = 1'b0;
      if (lat >= 100) check(1'b0, "R5", "no ready pulse", real'(lat), 13.0);
      q = longint'(quotient);
      starts = n_starts - s0;
      @(negedge clk);
      check(!ready && !busy, "R6", "ready/busy after pulse", real'(ready), 0.0);
   endtask

   task automatic judge(input int n, input int d, input bit two,
                        input longint q, input int lat, input int starts);
      real ideal, lo;
      string tag;
      ideal = real'(n) * UNITY / real'(d);
      tag = two ? "R3" : "R2";
      lo = two ? ideal - ideal / 8192.0 - 2.0 : ideal - ideal / 1024.0 - 2.0;
      check(real'(q) <= ideal + 1.0e-6, tag, "above exact quotient", real'(q), ideal);
      check(real'(q) >= lo, tag, "below error bound", real'(q), lo);
      check(lat == (two ? 21 : 13), "R5", "latency", real'(lat), two ? 21.0 : 13.0);
      check(starts == (two ? 5 : 3), "R8", "multiply count", real'(starts), two ? 5.0 : 3.0);
      if (n == d) begin
         lo = two ? UNITY - 2.0 : UNITY - 32.0 - 2.0;
         check(real'(q) >= lo && real'(q) <= UNITY, "R4", "unity band",
               real'(q), UNITY);
      end
   endtask

   task automatic sweep(input int pat, input bit two);
      int d, n, dv, lat, st;
      longint q;
      d = 1;
      forever begin
         case (pat)
            0:       begin n = d;        dv = d;        end
            1:       begin n = d;        dv = d + 2500; end
            default: begin n = d + 2500; dv = d;        end
         endcase
         if (dv <= 32767) begin
            run_div(n, dv, two, 1'b0, q, lat, st);
            judge(n, dv, two, q, lat, st);
         end
         if (d == 32767) break;
         d = d + 1 + d / 64;
         if (d > 32767) d = 32767;
      end
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      check(1'b0, "R5", "watchdog expired", 0.0, 1.0);
      summary();
      $finish;
   end

   initial begin : main
      longint q, q0;
      int lat, st, r0;
      repeat (3) @(negedge clk);
      // R10: state held in reset
      check(!busy && !ready && !mul_start, "R10", "control outputs in reset",
            real'(busy | ready | mul_start), 0.0);
      check(quotient == '0, "R10", "quotient in reset", real'(quotient), 0.0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R7: request injected while busy is ignored
      r0 = n_ready;
      run_div(1000, 7, 1'b0, 1'b1, q, lat, st);
      judge(1000, 7, 1'b0, q, lat, st);
      repeat (30) @(negedge clk);
      check(n_ready - r0 == 1, "R7", "results after injected request",
            real'(n_ready - r0), 1.0);
      check(!busy, "R7", "idle after injected request", real'(busy), 0.0);

      // R9: quotient held while idle with moving inputs
      q0 = longint'(quotient);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         req_dividend = W'(i * 77 + 3);
         req_divisor  = W'(i * 131 + 1);
         req_two_pass = i[0];
      end
      @(negedge clk);
      check(longint'(quotient) == q0, "R9", "quotient held while idle",
            real'(quotient), real'(q0));

      // R1..R5, R8: sweeps of three patterns at both pass counts
      for (int p = 0; p < 3; p++) begin
         sweep(p, 1'b0);
         sweep(p, 1'b1);
      end

      summary();
      $finish;
   end

endmodule